// File: doc/BRIEF.md
# Online Arrival-Curve Characterizer

This block watches a valid/ready handshake and, for every window of 2^N clock cycles, reports how much traffic passed (an average-rate figure) and how bursty it was (a burstiness figure fitted to a rate-plus-burst arrival curve). The burstiness is found on line. The block keeps a single candidate critical point and moves it when the running slope through the current sample beats the slope through the candidate. It makes that slope comparison with one signed difference that is updated by additions only. Time and packet count each grow by at most one per cycle, so no per-cycle multiplier is needed.

Several characterizer instances run staggered by a prediction period of Lw/PHASES cycles. The windows overlap as a sliding window, and a new report appears every prediction period. A one-hot multiplexer forwards whichever instance is reporting. A small forecast stage then extrapolates the next average rate from the last two reports and carries the burstiness forward unchanged. Packet length and peak rate are taken as one packet and 100 percent, so they need no hardware.

Top module: `arc_curve_char`

## Requirements
- R1: A packet is counted in a cycle only when in_valid and in_ready are both high at that clock edge; valid alone or ready alone adds nothing.
- R2: The window length is Lw = 2^N cycles, and rep_rho is the number of packets counted within the window (0 to Lw), with Lw as the implied denominator.
- R3: Within a window, time t runs 1..Lw and f(t) is the count up to and including cycle t. The candidate (tc, f(tc)) starts empty (tc = 0) and is replaced by (t, f(t)) when tc = 0 or f(tc)*t < f(t)*tc. The comparison uses only an add/subtract difference that is cleared on each replacement.
- R4: rep_sigma = f(tc) - (f(Lw) >> N) * tc, using the final candidate of the window.
- R5: With PW = Lw/PHASES, instance i starts counting i*PW cycles after reset is released. Report j (j = 0, 1, ...) therefore covers cycles j*PW through j*PW+Lw-1, counted from the first cycle after reset.
- R6: rep_valid is a one-cycle pulse during cycle e+3, where e is the index of the last cycle of the window. fc_valid pulses one cycle after rep_valid.
- R7: At most one instance reports in any cycle, and consecutive reports are exactly PW cycles apart.
- R8: On each forecast, fc_sigma equals the reported sigma, and fc_rho = 2*rho_n - rho_(n-1) clamped to 0..Lw, where rho_(n-1) is 0 for the first report after reset.
- R9: The synchronous active-high reset clears all state; while reset is held, rep_valid and fc_valid are 0 and all value outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Valid of the observed handshake |
| in_ready | input | 1 | Ready of the observed handshake |
| rep_valid | output | 1 | One-cycle pulse marking a window report |
| rep_sigma | output | N+1 | Burstiness of the reported window, in packets |
| rep_rho | output | N+1 | Packet count of the reported window |
| fc_valid | output | 1 | One-cycle pulse marking a forecast |
| fc_sigma | output | N+1 | Forecast burstiness |
| fc_rho | output | N+1 | Forecast packet count, clamped to 0..Lw |

## Verification
Saturated traffic is the sharpest corner. Here f(Lw) >> N becomes 1 and the correction term must cancel the candidate, giving sigma 0. A design that drops the shift term, or picks the wrong candidate, reports a nonzero burst. Handshakes with only one side high must leave the count at zero, or the design overcounts. A falling rate drives the extrapolation below zero and a rising one drives it above Lw, so a design without saturation wraps to a large or small value. Each report is checked against the exact overlapping window it must cover and the exact cycle it must appear in, which exposes an instance started at the wrong offset or a pipeline stage added or missed.

// File: rtl/arc_pkg.sv
package arc_pkg;

  typedef enum logic {PH_WAIT, PH_RUN} phase_e;

  // start offset of staggered instance idx for window 2^n split into phases
  function automatic int unsigned phase_offset(int unsigned idx, int unsigned n,
                                               int unsigned phases);
    return idx * ((32'd1 << n) / phases);
  endfunction

endpackage

// File: rtl/arc_window.sv
module arc_window
  import arc_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned OFFSET = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_ready,
  output logic         rpt_valid,
  output logic [N:0]   rpt_sigma,
  output logic [N:0]   rpt_rho
);
  localparam int unsigned LW       = 1 << N;
  localparam int unsigned CW       = N + 1;
  localparam int unsigned DW       = 2 * N + 4;
  localparam int unsigned OFF_LAST = (OFFSET > 0) ? OFFSET - 1 : 0;
  localparam phase_e      RST_PH   = (OFFSET == 0) ? PH_RUN : PH_WAIT;

  phase_e                ph_q;
  logic [CW-1:0]         dly_q;
  logic [CW-1:0]         t_q, f_q, tc_q, ftc_q;
  logic signed [DW-1:0]  d_q;
  logic [CW-1:0]         snap_f, snap_tc, snap_ftc;
  logic                  pend_q;

  logic                  hit, take, last;
  logic [CW-1:0]         t_n, f_n, tc_nx, ftc_nx;
  logic signed [DW-1:0]  d_try, d_nx;
  logic [2*CW-1:0]       prod;

  always_comb begin
    hit    = in_valid & in_ready;
    t_n    = t_q + CW'(1);
    f_n    = f_q + CW'(hit);
    // running value of f(tc)*t - f(t)*tc, kept by additions only
    d_try  = d_q + $signed(DW'(ftc_q)) - (hit ? $signed(DW'(tc_q)) : '0);
    take   = (tc_q == '0) || d_try[DW-1];
    tc_nx  = take ? t_n : tc_q;
    ftc_nx = take ? f_n : ftc_q;
    d_nx   = take ? '0 : d_try;
    last   = (t_n == CW'(LW));
    prod   = (2*CW)'(snap_f >> N) * (2*CW)'(snap_tc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= RST_PH;
      dly_q     <= '0;
      t_q       <= '0;
      f_q       <= '0;
      tc_q      <= '0;
      ftc_q     <= '0;
      d_q       <= '0;
      snap_f    <= '0;
      snap_tc   <= '0;
      snap_ftc  <= '0;
      pend_q    <= 1'b0;
      rpt_valid <= 1'b0;
      rpt_sigma <= '0;
      rpt_rho   <= '0;
    end else begin
      pend_q    <= 1'b0;
      rpt_valid <= pend_q;
      if (pend_q) begin
        rpt_sigma <= snap_ftc - prod[CW-1:0];
        rpt_rho   <= snap_f;
      end
      if (ph_q == PH_WAIT) begin
        dly_q <= dly_q + CW'(1);
        if (dly_q == CW'(OFF_LAST)) ph_q <= PH_RUN;
      end else if (last) begin
        snap_f   <= f_n;
        snap_tc  <= tc_nx;
        snap_ftc <= ftc_nx;
        pend_q   <= 1'b1;
        t_q      <= '0;
        f_q      <= '0;
        tc_q     <= '0;
        ftc_q    <= '0;
        d_q      <= '0;
      end else begin
        t_q   <= t_n;
        f_q   <= f_n;
        tc_q  <= tc_nx;
        ftc_q <= ftc_nx;
        d_q   <= d_nx;
      end
    end
  end

  // R1
  count_le_time_chk: assert property (@(posedge clk) disable iff (rst)
    f_q <= t_q);

  // R3
  cand_below_diag_chk: assert property (@(posedge clk) disable iff (rst)
    ftc_q <= tc_q);

  // R3
  diff_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
    !d_q[DW-1]);

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |=> !rpt_valid);

endmodule

// File: rtl/arc_forecast.sv
module arc_forecast #(
  parameter int unsigned N = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [N:0] in_sigma,
  input  logic [N:0] in_rho,
  output logic       fc_valid,
  output logic [N:0] fc_sigma,
  output logic [N:0] fc_rho
);
  localparam int unsigned LW = 1 << N;
  localparam int unsigned CW = N + 1;
  localparam int unsigned GW = CW + 3;

  logic [CW-1:0]        prev_q;
  logic signed [GW-1:0] guess;
  logic [CW-1:0]        clamped;

  always_comb begin
    guess = $signed({2'b00, in_rho, 1'b0}) - $signed({3'b000, prev_q});
    if (guess[GW-1])                     clamped = '0;
    else if (guess > $signed(GW'(LW)))   clamped = CW'(LW);
    else                                 clamped = guess[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      fc_valid <= 1'b0;
      fc_sigma <= '0;
      fc_rho   <= '0;
    end else begin
      fc_valid <= in_valid;
      if (in_valid) begin
        prev_q   <= in_rho;
        fc_sigma <= in_sigma;
        fc_rho   <= clamped;
      end
    end
  end

  // R8
  fc_range_chk: assert property (@(posedge clk) disable iff (rst)
    fc_valid |-> fc_rho <= CW'(LW));

  // R6
  fc_follows_chk: assert property (@(posedge clk) disable iff (rst)
    fc_valid |-> $past(in_valid));

endmodule

// File: rtl/arc_curve_char.sv
module arc_curve_char
  import arc_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned PHASES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_ready,
  output logic       rep_valid,
  output logic [N:0] rep_sigma,
  output logic [N:0] rep_rho,
  output logic       fc_valid,
  output logic [N:0] fc_sigma,
  output logic [N:0] fc_rho
);
  localparam int unsigned LW = 1 << N;
  localparam int unsigned CW = N + 1;

  logic [PHASES-1:0] win_v;
  logic [CW-1:0]     win_sig [PHASES];
  logic [CW-1:0]     win_rho [PHASES];
  logic [CW-1:0]     sel_sig, sel_rho;

  for (genvar gi = 0; gi < PHASES; gi++) begin : g_win
    arc_window #(
      .N      (N),
      .OFFSET (phase_offset(gi, N, PHASES))
    ) u_win (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .rpt_valid (win_v[gi]),
      .rpt_sigma (win_sig[gi]),
      .rpt_rho   (win_rho[gi])
    );
  end

  // one-hot selection of the reporting instance
  always_comb begin
    sel_sig = '0;
    sel_rho = '0;
    for (int i = 0; i < PHASES; i++) begin
      sel_sig = sel_sig | (win_sig[i] & {CW{win_v[i]}});
      sel_rho = sel_rho | (win_rho[i] & {CW{win_v[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_valid <= 1'b0;
      rep_sigma <= '0;
      rep_rho   <= '0;
    end else begin
      rep_valid <= |win_v;
      if (|win_v) begin
        rep_sigma <= sel_sig;
        rep_rho   <= sel_rho;
      end
    end
  end

  arc_forecast #(.N(N)) u_fc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rep_valid),
    .in_sigma (rep_sigma),
    .in_rho   (rep_rho),
    .fc_valid (fc_valid),
    .fc_sigma (fc_sigma),
    .fc_rho   (fc_rho)
  );

  // R7
  one_report_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_v));

  // R2
  rep_rho_range_chk: assert property (@(posedge clk) disable iff (rst)
    rep_valid |-> rep_rho <= CW'(LW));

endmodule

// File: tb/tb_arc_curve_char.sv
module tb_arc_curve_char;
  localparam int N          = 4;
  localparam int PHASES     = 2;
  localparam int LW         = 1 << N;
  localparam int PW         = LW / PHASES;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready = 1'b0;
  logic       rep_valid, fc_valid;
  logic [N:0] rep_sigma, rep_rho, fc_sigma, fc_rho;

  int  total = 0;
  int  fails = 0;
  int  k_cnt = 0;
  int  cyc   = 0;
  bit  hits [0:4095];

  arc_curve_char #(.N(N), .PHASES(PHASES)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .rep_valid(rep_valid), .rep_sigma(rep_sigma), .rep_rho(rep_rho),
    .fc_valid(fc_valid), .fc_sigma(fc_sigma), .fc_rho(fc_rho)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) k_cnt = 0;
    else begin
      if (k_cnt < 4096) hits[k_cnt] = in_valid && in_ready;
      k_cnt = k_cnt + 1;
    end
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] pat(int mode, int k);
    case (mode)
      1: return 2'b11;
      2: return (k % 2 == 0) ? 2'b10 : 2'b01;
      3: return ((k % 12) < 5) ? 2'b11 : 2'b00;
      4: return (k < 16) ? 2'b11 : 2'b00;
      5: return {((k*37+11) % 7) < 4, ((k*13+5) % 5) != 0};
      6: return (k < 24) ? {2{k % 4 == 0}} : 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // expected report j from the requirements (R2, R3, R4, R5)
  task automatic model(int j, output int sig, output int rho);
    int f = 0, tc = 0, ftc = 0;
    for (int t = 1; t <= LW; t++) begin
      f += int'(hits[j*PW + t - 1]);
      if (tc == 0 || ftc*t < f*tc) begin
        tc = t; ftc = f;
      end
    end
    rho = f;
    sig = ftc - (f >> N) * tc;
  endtask

  task automatic do_reset(int mode);
    rst = 1'b1; in_valid = 1'b0; in_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "rep_valid in reset", int'(rep_valid), 0);
    chk("R9", "fc_valid in reset", int'(fc_valid), 0);
    chk("R9", "rep_rho in reset", int'(rep_rho), 0);
    chk("R9", "fc_rho in reset", int'(fc_rho), 0);
    rst = 1'b0;
    {in_valid, in_ready} = pat(mode, 0);
  endtask

  task automatic run_mode(int mode, int nrep, string rho_req, string tag);
    int j = 0, fj = 0, prev = 0, guard = 0;
    int s, r, g, exp_fc_rho = 0, exp_fc_sig = 0;
    do_reset(mode);
    while (fj < nrep && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (fc_valid) begin
        chk("R8", {tag, " fc_rho"}, int'(fc_rho), exp_fc_rho);
        chk("R8", {tag, " fc_sigma"}, int'(fc_sigma), exp_fc_sig);
        chk("R6", {tag, " fc timing"}, k_cnt, LW + 3 + fj*PW);
        fj++;
      end
      if (rep_valid) begin
        model(j, s, r);
        chk(rho_req, {tag, " rho"}, int'(rep_rho), r);
        chk("R3/R4", {tag, " sigma"}, int'(rep_sigma), s);
        chk("R5/R6/R7", {tag, " report timing"}, k_cnt, LW + 2 + j*PW);
        g = 2*r - prev;
        if (g < 0) g = 0;
        if (g > LW) g = LW;
        exp_fc_rho = g; exp_fc_sig = s; prev = r;
        j++;
      end
      {in_valid, in_ready} = pat(mode, k_cnt);
    end
    chk("R6", {tag, " forecast count"}, fj, nrep);
  endtask

  task automatic t_idle;      run_mode(0, 4, "R2", "idle");            endtask
  task automatic t_full;      run_mode(1, 4, "R2", "saturated");       endtask
  task automatic t_half_hs;   run_mode(2, 4, "R1", "one-sided");       endtask
  task automatic t_burst;     run_mode(3, 6, "R2", "periodic burst");  endtask
  task automatic t_drop;      run_mode(4, 5, "R2", "falling rate");    endtask
  task automatic t_mixed;     run_mode(5, 8, "R1", "mixed handshake"); endtask
  task automatic t_rise;      run_mode(6, 6, "R2", "rising rate");     endtask

  initial begin
    t_idle();
    t_full();
    t_half_hs();
    t_burst();
    t_drop();
    t_mixed();
    t_rise();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule